// File: doc/BRIEF.md
# YCbCr Level Adjust Pipeline

This block adjusts the levels of a 10-bit YCbCr pixel stream, one sample per cycle. On the luma channel it applies a contrast gain centred on mid-code, then adds a brightness offset, then clamps the result. On the two chroma channels it applies one shared saturation gain centred on the chroma zero point, then clamps. Three 8-bit controls (contrast, brightness, saturation) and one range bit steer it. The range bit chooses between studio limits and a wider extended window.

Each sample enters with a valid strobe and leaves exactly three cycles later, together with its delayed strobe. The control values are captured with each sample. A control change therefore affects only the samples accepted after it. All intermediate arithmetic is signed and wide enough that no value wraps before the clamp.

Top module: `ycc_level_adjust`

## Requirements
- R1: A sample accepted with valid_i high at a rising edge appears on the outputs after the third rising edge that follows it. valid_o is high for exactly those cycles, so valid_o equals valid_i delayed by 3 cycles.
- R2: Luma output before clamping is floor(((y-512)*contrast + 64)/128) + 512 + (brightness-128)*4. A contrast code of 128 is unity gain.
- R3: With brightness at 128, a luma input of 512 gives 512 at every contrast code.
- R4: A brightness code b shifts luma by (b-128)*4. Code 0 gives -512, 128 gives 0 and 255 gives +508.
- R5: With range_ext_i = 0, luma is clamped to the range 64 to 940.
- R6: With range_ext_i = 1, luma, Cb and Cr are all clamped to the range 4 to 1019.
- R7: Cb and Cr before clamping are floor(((c-512)*saturation + 64)/128) + 512. The same saturation code applies to both.
- R8: A chroma input of 512 gives 512 at every saturation code.
- R9: With range_ext_i = 0, Cb and Cr are clamped to the range 64 to 960.
- R10: Scaled products round half up. With unity offset, luma 513 at contrast 64 gives 513, and luma 511 at contrast 64 gives 512.
- R11: After reset, valid_o is 0 and every data output is 0. While valid_o is low, the data outputs hold their last value.
- R12: The contrast, brightness, saturation and range inputs are sampled in the same cycle as their pixel. Changing them after that edge does not alter that pixel's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample strobe |
| y_i | input | 10 | Luma in |
| cb_i | input | 10 | Blue-difference chroma in |
| cr_i | input | 10 | Red-difference chroma in |
| contrast_i | input | 8 | Luma gain, 128 = unity |
| brightness_i | input | 8 | Luma offset code, 128 = none |
| saturation_i | input | 8 | Chroma gain, 128 = unity |
| range_ext_i | input | 1 | 0 = studio clamp, 1 = extended clamp |
| valid_o | output | 1 | Output sample strobe |
| y_o | output | 10 | Adjusted luma |
| cb_o | output | 10 | Adjusted Cb |
| cr_o | output | 10 | Adjusted Cr |

## Verification
Every result is due after the third rising edge that follows the edge accepting its sample. Inputs are driven on falling edges. Each single-sample scenario therefore reads valid_o and the data on the third falling edge after the driving one. It also confirms that valid_o is still low one falling edge earlier and that the data are held one falling edge later. The streaming scenario drives one sample per falling edge and reads sample k on falling edge k+3. The settings scenario changes the controls on the falling edge right after acceptance and then expects the result of the original controls.

// File: rtl/ycc_level_pkg.sv
package ycc_level_pkg;
  localparam int unsigned DATA_W_DEF = 10;
  localparam int unsigned GAIN_W_DEF = 8;
  localparam int unsigned LATENCY    = 3;

  typedef enum logic [1:0] {CH_Y = 2'd0, CH_CB = 2'd1, CH_CR = 2'd2} chan_e;

  // Limits scale with sample width; 8-bit studio values shifted up.
  function automatic int unsigned lim_lo_std(input int unsigned dw);
    return 16 << (dw - 8);
  endfunction
  function automatic int unsigned lim_hi_luma(input int unsigned dw);
    return 235 << (dw - 8);
  endfunction
  function automatic int unsigned lim_hi_chroma(input int unsigned dw);
    return 240 << (dw - 8);
  endfunction
  function automatic int unsigned lim_lo_ext(input int unsigned dw);
    return 1 << (dw - 8);
  endfunction
  function automatic int unsigned lim_hi_ext(input int unsigned dw);
    return ((1 << dw) - 1) - (1 << (dw - 8));
  endfunction
endpackage

// File: rtl/valid_pipe.sv
module valid_pipe #(
  parameter int unsigned DEPTH = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  output logic [DEPTH-1:0] stage_o
);
  logic [DEPTH-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[DEPTH-2:0], valid_i};
  end

  assign stage_o = sr_q;
endmodule

// File: rtl/chan_scale.sv
// Stages 1-2: centre on mid-code, multiply by gain/2^(GAIN_W-1), round half up.
module chan_scale #(
  parameter int unsigned DATA_W = 10,
  parameter int unsigned GAIN_W = 8,
  localparam int unsigned PW    = DATA_W + GAIN_W + 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en1_i,
  input  logic                 en2_i,
  input  logic [DATA_W-1:0]    data_i,
  input  logic [GAIN_W-1:0]    gain_i,
  output logic signed [PW-1:0] scaled_o
);
  localparam int unsigned MID = 1 << (DATA_W - 1);
  localparam int unsigned RND = 1 << (GAIN_W - 2);
  localparam int unsigned SH  = GAIN_W - 1;

  logic signed [DATA_W:0] cen_d, cen_q;
  logic [GAIN_W-1:0]      gain_q;
  logic signed [PW-1:0]   prod, rnd, scaled_d, scaled_q;

  assign cen_d = $signed({1'b0, data_i}) - $signed((DATA_W+1)'(MID));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cen_q  <= '0;
      gain_q <= '0;
    end else if (en1_i) begin
      cen_q  <= cen_d;
      gain_q <= gain_i;
    end
  end

  assign prod     = PW'(cen_q) * $signed({{(PW-GAIN_W){1'b0}}, gain_q});
  assign rnd      = prod + $signed(PW'(RND));
  assign scaled_d = rnd >>> SH;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    scaled_q <= '0;
    else if (en2_i) scaled_q <= scaled_d;
  end

  assign scaled_o = scaled_q;
endmodule

// File: rtl/chan_finish.sv
// Stage 3: restore mid-code, add offset, clamp to the selected window.
module chan_finish #(
  parameter int unsigned DATA_W = 10,
  parameter int unsigned PW     = 20,
  parameter int unsigned LO_STD = 64,
  parameter int unsigned HI_STD = 940,
  parameter int unsigned LO_EXT = 4,
  parameter int unsigned HI_EXT = 1019
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic signed [PW-1:0] scaled_i,
  input  logic signed [PW-1:0] offset_i,
  input  logic                 ext_i,
  output logic [DATA_W-1:0]    data_o
);
  localparam int unsigned SW  = PW + 1;
  localparam int unsigned MID = 1 << (DATA_W - 1);

  logic signed [SW-1:0] sum, lo, hi;
  logic [DATA_W-1:0]    clamp_d, data_q;

  assign sum = SW'(scaled_i) + SW'(offset_i) + $signed(SW'(MID));
  assign lo  = ext_i ? $signed(SW'(LO_EXT)) : $signed(SW'(LO_STD));
  assign hi  = ext_i ? $signed(SW'(HI_EXT)) : $signed(SW'(HI_STD));

  always_comb begin
    if (sum < lo)      clamp_d = lo[DATA_W-1:0];
    else if (sum > hi) clamp_d = hi[DATA_W-1:0];
    else               clamp_d = sum[DATA_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   data_q <= '0;
    else if (en_i) data_q <= clamp_d;
  end

  assign data_o = data_q;
endmodule

// File: rtl/ycc_level_adjust.sv
module ycc_level_adjust
  import ycc_level_pkg::*;
#(
  parameter int unsigned DATA_W = DATA_W_DEF,
  parameter int unsigned GAIN_W = GAIN_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] y_i,
  input  logic [DATA_W-1:0] cb_i,
  input  logic [DATA_W-1:0] cr_i,
  input  logic [GAIN_W-1:0] contrast_i,
  input  logic [GAIN_W-1:0] brightness_i,
  input  logic [GAIN_W-1:0] saturation_i,
  input  logic              range_ext_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] y_o,
  output logic [DATA_W-1:0] cb_o,
  output logic [DATA_W-1:0] cr_o
);
  localparam int unsigned NCH  = 3;
  localparam int unsigned PW   = DATA_W + GAIN_W + 2;
  localparam int unsigned BMID = 1 << (GAIN_W - 1);
  localparam int unsigned BSH  = DATA_W - GAIN_W;

  logic [LATENCY-1:0] vld;
  logic [DATA_W-1:0]  din  [NCH];
  logic [DATA_W-1:0]  dout [NCH];

  // Side pipeline for controls used at stage 3.
  logic [GAIN_W-1:0]    bri_q1, bri_q2;
  logic                 ext_q1, ext_q2;
  logic signed [PW-1:0] bri_off;

  valid_pipe #(.DEPTH(LATENCY)) u_vpipe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .stage_o(vld)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bri_q1 <= '0;
      bri_q2 <= '0;
      ext_q1 <= 1'b0;
      ext_q2 <= 1'b0;
    end else begin
      if (valid_i) begin
        bri_q1 <= brightness_i;
        ext_q1 <= range_ext_i;
      end
      if (vld[0]) begin
        bri_q2 <= bri_q1;
        ext_q2 <= ext_q1;
      end
    end
  end

  assign bri_off = ($signed({{(PW-GAIN_W){1'b0}}, bri_q2}) - $signed(PW'(BMID))) <<< BSH;

  assign din[CH_Y]  = y_i;
  assign din[CH_CB] = cb_i;
  assign din[CH_CR] = cr_i;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    localparam bit IS_LUMA = (ch == int'(CH_Y));
    localparam int unsigned HI_STD = IS_LUMA ? lim_hi_luma(DATA_W) : lim_hi_chroma(DATA_W);

    logic [GAIN_W-1:0]    gain;
    logic signed [PW-1:0] scaled, offset;

    assign gain   = IS_LUMA ? contrast_i : saturation_i;
    assign offset = IS_LUMA ? bri_off : '0;

    chan_scale #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) u_scale (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en1_i   (valid_i),
      .en2_i   (vld[0]),
      .data_i  (din[ch]),
      .gain_i  (gain),
      .scaled_o(scaled)
    );

    chan_finish #(
      .DATA_W(DATA_W),
      .PW    (PW),
      .LO_STD(lim_lo_std(DATA_W)),
      .HI_STD(HI_STD),
      .LO_EXT(lim_lo_ext(DATA_W)),
      .HI_EXT(lim_hi_ext(DATA_W))
    ) u_finish (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (vld[1]),
      .scaled_i(scaled),
      .offset_i(offset),
      .ext_i   (ext_q2),
      .data_o  (dout[ch])
    );
  end

  assign valid_o = vld[LATENCY-1];
  assign y_o     = dout[CH_Y];
  assign cb_o    = dout[CH_CB];
  assign cr_o    = dout[CH_CR];
endmodule

// File: rtl/ycc_level_adjust_chk.sv
module ycc_level_adjust_chk #(
  parameter int unsigned DATA_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              range_ext_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] y_o,
  input logic [DATA_W-1:0] cb_o,
  input logic [DATA_W-1:0] cr_o
);
  localparam logic [DATA_W-1:0] LO_STD = DATA_W'(16 << (DATA_W - 8));
  localparam logic [DATA_W-1:0] HI_Y   = DATA_W'(235 << (DATA_W - 8));
  localparam logic [DATA_W-1:0] HI_C   = DATA_W'(240 << (DATA_W - 8));
  localparam logic [DATA_W-1:0] LO_EXT = DATA_W'(1 << (DATA_W - 8));
  localparam logic [DATA_W-1:0] HI_EXT = DATA_W'(((1 << DATA_W) - 1) - (1 << (DATA_W - 8)));

  logic [2:0] v_sr, e_sr;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_sr <= '0;
      e_sr <= '0;
    end else begin
      v_sr <= {v_sr[1:0], valid_i};
      e_sr <= {e_sr[1:0], range_ext_i};
    end
  end

  // R1
  a_r1_valid_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == v_sr[2]);

  // R5
  a_r5_luma_studio: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !e_sr[2]) |-> (y_o >= LO_STD && y_o <= HI_Y));

  // R9
  a_r9_chroma_studio: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !e_sr[2]) |-> (cb_o >= LO_STD && cb_o <= HI_C && cr_o >= LO_STD && cr_o <= HI_C));

  // R6
  a_r6_ext_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (y_o >= LO_EXT && y_o <= HI_EXT && cb_o >= LO_EXT && cb_o <= HI_EXT
                 && cr_o >= LO_EXT && cr_o <= HI_EXT));

  // R11
  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(y_o) && $stable(cb_o) && $stable(cr_o)));
endmodule

bind ycc_level_adjust ycc_level_adjust_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .range_ext_i(range_ext_i),
  .valid_o    (valid_o),
  .y_o        (y_o),
  .cb_o       (cb_o),
  .cr_o       (cr_o)
);

// File: tb/ycc_level_adjust_bench.sv
`timescale 1ns/1ps
module ycc_level_adjust_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [9:0] y_i = '0, cb_i = '0, cr_i = '0;
  logic [7:0] contrast_i = 8'd128, brightness_i = 8'd128, saturation_i = 8'd128;
  logic       range_ext_i = 1'b0;
  logic       valid_o;
  logic [9:0] y_o, cb_o, cr_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #2.5 clk_i = ~clk_i;

  ycc_level_adjust u_ycc_level_adjust (
    .clk_i, .rst_ni, .valid_i, .y_i, .cb_i, .cr_i,
    .contrast_i, .brightness_i, .saturation_i, .range_ext_i,
    .valid_o, .y_o, .cb_o, .cr_o
  );

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual=%0d expected<=100000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  function automatic int clampv(int v, int lo, int hi);
    return (v < lo) ? lo : (v > hi) ? hi : v;
  endfunction

  function automatic int exp_y(int y, int c, int b, bit ext);
    int v;
    v = (((y - 512) * c + 64) >>> 7) + 512 + (b - 128) * 4;
    return ext ? clampv(v, 4, 1019) : clampv(v, 64, 940);
  endfunction

  function automatic int exp_c(int x, int s, bit ext);
    int v;
    v = (((x - 512) * s + 64) >>> 7) + 512;
    return ext ? clampv(v, 4, 1019) : clampv(v, 64, 960);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive one sample, check latency, result and hold.
  task automatic one(string req, int y, int cb, int cr, int c, int b, int s, bit ext);
    @(negedge clk_i);
    valid_i = 1; y_i = 10'(y); cb_i = 10'(cb); cr_i = 10'(cr);
    contrast_i = 8'(c); brightness_i = 8'(b); saturation_i = 8'(s); range_ext_i = ext;
    @(negedge clk_i); valid_i = 0;
    @(negedge clk_i); chk({req, " R1 early"}, int'(valid_o), 0);
    @(negedge clk_i); chk({req, " R1 valid"}, int'(valid_o), 1);
    chk({req, " y"},  int'(y_o),  exp_y(y, c, b, ext));
    chk({req, " cb"}, int'(cb_o), exp_c(cb, s, ext));
    chk({req, " cr"}, int'(cr_o), exp_c(cr, s, ext));
    @(negedge clk_i);
    chk({req, " R11 hold y"},  int'(y_o),  exp_y(y, c, b, ext));
    chk({req, " R11 hold cb"}, int'(cb_o), exp_c(cb, s, ext));
  endtask

  task automatic t_reset();
    chk("R11 reset valid", int'(valid_o), 0);
    chk("R11 reset y", int'(y_o), 0);
    chk("R11 reset cb", int'(cb_o), 0);
    chk("R11 reset cr", int'(cr_o), 0);
  endtask

  task automatic t_gain();
    one("R2 unity",      300, 700, 200, 128, 128, 128, 0);
    one("R2 contrast200", 700, 512, 512, 200, 128, 128, 0);
    one("R2 contrast40",  300, 512, 512, 40,  128, 128, 1);
    one("R7 sat200",     512, 600, 430, 128, 128, 200, 0);
    one("R7 sat60",      512, 900, 100, 128, 128, 60,  1);
  endtask

  task automatic t_mid();
    one("R3 mid c0",   512, 512, 512, 0,   128, 0,   0);
    one("R3 mid c255", 512, 512, 512, 255, 128, 255, 0);
    one("R8 neutral",  512, 512, 512, 77,  128, 201, 1);
    chk("R3 mid literal", int'(y_o), 512);
    chk("R8 neutral literal", int'(cr_o), 512);
  endtask

  task automatic t_bright();
    one("R4 b255", 300, 512, 512, 128, 255, 128, 0);
    chk("R4 +508 literal", int'(y_o), 808);
    one("R4 b0 ext", 600, 512, 512, 128, 0, 128, 1);
    chk("R4 -512 literal", int'(y_o), 88);
  endtask

  task automatic t_clamp();
    one("R5 top",    1000, 1000, 10, 128, 128, 128, 0);
    chk("R5 940", int'(y_o), 940);
    chk("R9 960", int'(cb_o), 960);
    chk("R9 64",  int'(cr_o), 64);
    one("R5 bottom", 300, 512, 512, 128, 0, 128, 0);
    chk("R5 64", int'(y_o), 64);
    one("R6 top",    1023, 1023, 0, 128, 128, 128, 1);
    chk("R6 1019", int'(y_o), 1019);
    chk("R6 cb 1019", int'(cb_o), 1019);
    chk("R6 cr 4", int'(cr_o), 4);
    one("R6 bottom", 300, 512, 512, 128, 0, 128, 1);
    chk("R6 4", int'(y_o), 4);
    one("R9 sat255", 512, 900, 124, 128, 128, 255, 0);
  endtask

  task automatic t_round();
    one("R10 up",   513, 513, 511, 64, 128, 64, 0);
    chk("R10 513", int'(y_o), 513);
    chk("R10 cr 512", int'(cr_o), 512);
    one("R10 half", 511, 512, 512, 64, 128, 128, 0);
    chk("R10 512", int'(y_o), 512);
  endtask

  task automatic t_stream();
    int ys[4] = '{100, 800, 512, 950};
    int cs[4] = '{64, 250, 128, 255};
    @(negedge clk_i);
    for (int k = 0; k < 7; k++) begin
      if (k < 4) begin
        valid_i = 1; y_i = 10'(ys[k]); cb_i = 10'(1023 - ys[k]); cr_i = 10'(ys[k]);
        contrast_i = 8'(cs[k]); saturation_i = 8'(cs[k]); brightness_i = 8'd140; range_ext_i = k[0];
      end else valid_i = 0;
      if (k >= 3) begin
        chk("R1 stream valid", int'(valid_o), 1);
        chk("R2 stream y", int'(y_o), exp_y(ys[k-3], cs[k-3], 140, (k-3) % 2 == 1));
        chk("R7 stream cb", int'(cb_o), exp_c(1023 - ys[k-3], cs[k-3], (k-3) % 2 == 1));
      end
      @(negedge clk_i);
    end
    chk("R1 stream end", int'(valid_o), 0);
  endtask

  task automatic t_late_change();
    @(negedge clk_i);
    valid_i = 1; y_i = 10'd700; cb_i = 10'd800; cr_i = 10'd300;
    contrast_i = 8'd100; brightness_i = 8'd150; saturation_i = 8'd90; range_ext_i = 1'b0;
    @(negedge clk_i);
    valid_i = 0; contrast_i = 8'd255; brightness_i = 8'd0; saturation_i = 8'd0; range_ext_i = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R12 y", int'(y_o), exp_y(700, 100, 150, 0));
    chk("R12 cb", int'(cb_o), exp_c(800, 90, 0));
    chk("R12 cr", int'(cr_o), exp_c(300, 90, 0));
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_gain();
    t_mid();
    t_bright();
    t_clamp();
    t_round();
    t_stream();
    t_late_change();
    repeat (2) @(negedge clk_i);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule